// File: doc/BRIEF.md
# System Status Register Bank

This block sits beside a small 32-bit load/store core and provides a second bank of 32 registers. This bank is separate from the general-purpose register file. The core uses a move-to write to put a value into this bank. Software uses it to report results, such as pass or fail, to a host. A move-from read returns a bank value to the execute logic combinationally, in the same cycle the index is presented. Two of the slots are not storage. They show a free-running cycle counter and a retired-instruction counter.

The core presents one completion strobe for every instruction it finishes. That strobe always counts one retired instruction. It also carries an optional destination reference. A reference is a kind bit plus a 5-bit index. Only a valid reference whose kind is "system" writes the bank. Every such write is also queued toward the host as an (index, data) pair. When the host queue is full, the core is held off through a ready signal.

The host starts the core by supplying a start PC. Until that happens, the block is idle: no counter advances and every completion strobe has no effect.

Top module: `sysreg_bank`

## Requirements
- R1: After synchronous reset: `running` is 0, `start_pc_out` is 0, `done_ready` is 1, `host_out_valid` is 0, and every read index returns 0.
- R2: A cycle with `host_start_valid` high makes `running` 1 and `start_pc_out` equal to `host_start_pc` from the next cycle onward.
- R3: While `running` is 1, the cycle counter grows by exactly one per clock. It is read at index 10.
- R4: Every completion strobe accepted while running adds one to the instruction counter, read at index 11. A strobe is accepted when `done_valid` and `done_ready` are both high. This holds whether or not the strobe writes.
- R5: An accepted strobe with `done_dst_valid`=1 and `done_dst_kind`=1 (1 = system bank, 0 = general register) stores `done_data` at `done_dst_idx`. A read of that index returns the value combinationally. Other indices keep their contents.
- R6: An accepted strobe with `done_dst_valid`=0, or with `done_dst_kind`=0, writes no bank register and sends nothing to the host.
- R7: Each bank write appears once on the host output as (`host_out_idx`, `host_out_data`), in write order. An item leaves on a cycle where `host_out_valid` and `host_out_ready` are both high.
- R8: The host queue holds 4 items. While it is full, `done_ready` is 0 and a held strobe is not counted. It is accepted once an item drains.
- R9: While `running` is 0, strobes have no effect: no count, no write and no host item. The cycle counter also stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start_valid | input | 1 | Host start request |
| host_start_pc | input | 32 | Start PC supplied with the request |
| start_pc_out | output | 32 | Latched start PC for the core |
| running | output | 1 | Core enabled |
| rd_idx | input | 5 | Move-from read index |
| rd_data | output | 32 | Read value (combinational) |
| done_valid | input | 1 | Instruction completion strobe |
| done_ready | output | 1 | Completion can be accepted |
| done_dst_valid | input | 1 | Destination reference present |
| done_dst_kind | input | 1 | 1 = system bank, 0 = general register |
| done_dst_idx | input | 5 | Destination index |
| done_data | input | 32 | Result value of the instruction |
| host_out_valid | output | 1 | Host queue has an item |
| host_out_ready | input | 1 | Host takes the item |
| host_out_idx | output | 5 | Item register index |
| host_out_data | output | 32 | Item data |

## Verification
The completion port is driven with four kinds of pattern:
- strobes before start, which separate the idle gating from the normal path;
- system-bank writes, including an overwrite and the top index, which show storage and same-cycle read-back;
- strobes with no destination or a general-register destination, which separate counting from writing;
- writes while the host stalls, which fill the queue and show the back-pressure and a delayed, but not lost, completion.

A scoreboard holds every expected host item, so a missing, extra or reordered item is caught. Counter reads taken a known number of clocks apart show that the counter steps once per clock.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int SR_IDX_W  = 5;
    localparam int SR_DATA_W = 32;
    localparam int SR_QDEPTH = 4;
    localparam int SR_CYC_SLOT = 10;
    localparam int SR_INS_SLOT = 11;

    typedef enum logic {
        KIND_GPR = 1'b0,
        KIND_SYS = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic                 valid;
        reg_kind_e            kind;
        logic [SR_IDX_W-1:0]  idx;
    } reg_ref_t;

    function automatic logic targets_bank(reg_ref_t r);
        return r.valid && (r.kind == KIND_SYS);
    endfunction

endpackage

// File: rtl/sysreg_counters.sv
module sysreg_counters #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              retire,
    output logic [DATA_W-1:0] cyc_cnt,
    output logic [DATA_W-1:0] ins_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_cnt <= '0;
            ins_cnt <= '0;
        end else if (run) begin
            cyc_cnt <= cyc_cnt + 1'b1;
            if (retire) begin
                ins_cnt <= ins_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file #(
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 32,
    parameter int CYC_SLOT = 10,
    parameter int INS_SLOT = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    input  logic [DATA_W-1:0] cyc_cnt,
    input  logic [DATA_W-1:0] ins_cnt,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREGS = 1 << IDX_W;

    logic [DATA_W-1:0] bank [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                bank[i] <= wdata;
            end
        end
    end

    always_comb begin
        if (ridx == IDX_W'(CYC_SLOT)) begin
            rdata = cyc_cnt;
        end else if (ridx == IDX_W'(INS_SLOT)) begin
            rdata = ins_cnt;
        end else begin
            rdata = bank[ridx];
        end
    end
endmodule

// File: rtl/sysreg_hostq.sv
module sysreg_hostq #(
    parameter int W     = 37,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_item,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head      = slots[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (do_push && (wr_ptr == AW'(i))) begin
                slots[i] <= push_item;
            end
        end
    end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int IDX_W    = SR_IDX_W,
    parameter int DATA_W   = SR_DATA_W,
    parameter int QDEPTH   = SR_QDEPTH,
    parameter int CYC_SLOT = SR_CYC_SLOT,
    parameter int INS_SLOT = SR_INS_SLOT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_start_valid,
    input  logic [DATA_W-1:0] host_start_pc,
    output logic [DATA_W-1:0] start_pc_out,
    output logic              running,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_valid,
    output logic              done_ready,
    input  logic              done_dst_valid,
    input  logic              done_dst_kind,
    input  logic [IDX_W-1:0]  done_dst_idx,
    input  logic [DATA_W-1:0] done_data,
    output logic              host_out_valid,
    input  logic              host_out_ready,
    output logic [IDX_W-1:0]  host_out_idx,
    output logic [DATA_W-1:0] host_out_data
);
    localparam int ITEM_W = IDX_W + DATA_W;

    logic              q_full;
    logic              accept;
    logic              bank_we;
    logic [DATA_W-1:0] cyc_cnt;
    logic [DATA_W-1:0] ins_cnt;
    logic [ITEM_W-1:0] q_head;
    reg_ref_t          dst_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            running      <= 1'b0;
            start_pc_out <= '0;
        end else if (host_start_valid) begin
            running      <= 1'b1;
            start_pc_out <= host_start_pc;
        end
    end

    always_comb begin
        dst_ref.valid = done_dst_valid;
        dst_ref.kind  = reg_kind_e'(done_dst_kind);
        dst_ref.idx   = SR_IDX_W'(done_dst_idx);
    end

    assign done_ready = !q_full;
    assign accept     = done_valid && done_ready && running;
    assign bank_we    = accept && targets_bank(dst_ref);

    sysreg_counters #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .retire  (accept),
        .cyc_cnt (cyc_cnt),
        .ins_cnt (ins_cnt)
    );

    sysreg_file #(
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W),
        .CYC_SLOT (CYC_SLOT),
        .INS_SLOT (INS_SLOT)
    ) u_file (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we),
        .widx    (done_dst_idx),
        .wdata   (done_data),
        .ridx    (rd_idx),
        .cyc_cnt (cyc_cnt),
        .ins_cnt (ins_cnt),
        .rdata   (rd_data)
    );

    sysreg_hostq #(.W(ITEM_W), .DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (bank_we),
        .push_item ({done_dst_idx, done_data}),
        .pop       (host_out_ready),
        .head      (q_head),
        .not_empty (host_out_valid),
        .full      (q_full)
    );

    assign host_out_idx  = q_head[ITEM_W-1 -: IDX_W];
    assign host_out_data = q_head[DATA_W-1:0];
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              running,
    input logic              host_start_valid,
    input logic [DATA_W-1:0] host_start_pc,
    input logic [DATA_W-1:0] start_pc_out,
    input logic              done_valid,
    input logic              done_ready,
    input logic              done_dst_valid,
    input logic              done_dst_kind,
    input logic              host_out_valid,
    input logic              host_out_ready,
    input logic [DATA_W-1:0] cyc_cnt,
    input logic [DATA_W-1:0] ins_cnt
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!running && !host_out_valid && done_ready));

    a_r2_start_latch: assert property (@(posedge clk) disable iff (rst)
        host_start_valid |=> (running && start_pc_out == $past(host_start_pc)));

    a_r3_cycle_step: assert property (@(posedge clk) disable iff (rst)
        running |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

    a_r8_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        !done_ready |-> host_out_valid);

    a_r8_no_count_stalled: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_ready) |=> $stable(ins_cnt));

    a_r7_write_queued: assert property (@(posedge clk) disable iff (rst)
        (running && done_valid && done_ready && done_dst_valid && done_dst_kind)
        |=> host_out_valid);

    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        (!running && !host_start_valid) |=> ($stable(cyc_cnt) && $stable(ins_cnt)
                                             && !host_out_valid));

    a_r7_drain: assert property (@(posedge clk) disable iff (rst)
        (host_out_valid && host_out_ready && !done_valid) |=> done_ready);
endmodule

bind sysreg_bank sysreg_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .running          (running),
    .host_start_valid (host_start_valid),
    .host_start_pc    (host_start_pc),
    .start_pc_out     (start_pc_out),
    .done_valid       (done_valid),
    .done_ready       (done_ready),
    .done_dst_valid   (done_dst_valid),
    .done_dst_kind    (done_dst_kind),
    .host_out_valid   (host_out_valid),
    .host_out_ready   (host_out_ready),
    .cyc_cnt          (cyc_cnt),
    .ins_cnt          (ins_cnt)
);

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_start_valid = 1'b0;
    logic [31:0] host_start_pc = '0;
    logic [31:0] start_pc_out;
    logic        running;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        done_valid = 1'b0;
    logic        done_ready;
    logic        done_dst_valid = 1'b0;
    logic        done_dst_kind = 1'b0;
    logic [4:0]  done_dst_idx = '0;
    logic [31:0] done_data = '0;
    logic        host_out_valid;
    logic        host_out_ready = 1'b1;
    logic [4:0]  host_out_idx;
    logic [31:0] host_out_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [36:0] sb_q[$];

    always #4 clk = ~clk;

    sysreg_bank u_sysreg_bank (
        .clk(clk), .rst(rst),
        .host_start_valid(host_start_valid), .host_start_pc(host_start_pc),
        .start_pc_out(start_pc_out), .running(running),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .done_valid(done_valid), .done_ready(done_ready),
        .done_dst_valid(done_dst_valid), .done_dst_kind(done_dst_kind),
        .done_dst_idx(done_dst_idx), .done_data(done_data),
        .host_out_valid(host_out_valid), .host_out_ready(host_out_ready),
        .host_out_idx(host_out_idx), .host_out_data(host_out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
        @(negedge clk);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    // driver: one completion strobe, waits for acceptance, records expected host item
    task automatic strobe(input bit dv, input bit kind, input logic [4:0] idx,
                          input logic [31:0] data, input bit expect_item);
        @(negedge clk);
        done_valid = 1'b1; done_dst_valid = dv; done_dst_kind = kind;
        done_dst_idx = idx; done_data = data;
        #1;
        while (!done_ready) begin
            @(negedge clk);
            #1;
        end
        if (expect_item) sb_q.push_back({idx, data});
        @(posedge clk);
        #1;
        done_valid = 1'b0; done_dst_valid = 1'b0;
    endtask

    // monitor: compare each host item leaving the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && host_out_valid && host_out_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected host item", {27'd0, host_out_idx}, 32'd0);
                end else begin
                    logic [36:0] e;
                    e = sb_q.pop_front();
                    check(host_out_idx == e[36:32], "R7", "host idx",
                          {27'd0, host_out_idx}, {27'd0, e[36:32]});
                    check(host_out_data == e[31:0], "R7", "host data",
                          host_out_data, e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(running == 1'b0, "R1", "running", {31'd0, running}, 32'd0);
        check(start_pc_out == 32'd0, "R1", "start pc", start_pc_out, 32'd0);
        check(done_ready == 1'b1, "R1", "done_ready", {31'd0, done_ready}, 32'd1);
        check(host_out_valid == 1'b0, "R1", "host valid", {31'd0, host_out_valid}, 32'd0);
        read_reg(5'd3, v);  check(v == 32'd0, "R1", "reg3", v, 32'd0);
        read_reg(5'd11, v); check(v == 32'd0, "R1", "ins cnt", v, 32'd0);

        // R9 strobes before start are ignored
        strobe(1'b1, 1'b1, 5'd5, 32'hDEAD_0005, 1'b0);
        strobe(1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        read_reg(5'd5, v);  check(v == 32'd0, "R9", "reg5 unwritten", v, 32'd0);
        read_reg(5'd11, v); check(v == 32'd0, "R9", "ins cnt idle", v, 32'd0);
        read_reg(5'd10, v); check(v == 32'd0, "R9", "cyc cnt idle", v, 32'd0);
        check(host_out_valid == 1'b0, "R9", "no host item", {31'd0, host_out_valid}, 32'd0);

        // R2 start
        @(negedge clk);
        host_start_valid = 1'b1; host_start_pc = 32'h0040_0100;
        @(negedge clk);
        host_start_valid = 1'b0;
        #1;
        check(running == 1'b1, "R2", "running", {31'd0, running}, 32'd1);
        check(start_pc_out == 32'h0040_0100, "R2", "start pc", start_pc_out, 32'h0040_0100);

        // R3 cycle counter steps once per clock
        read_reg(5'd10, a);
        repeat (4) @(negedge clk);
        read_reg(5'd10, b);
        check(b == a + 32'd5, "R3", "cycle delta", b, a + 32'd5);

        // R5 writes and same-cycle readback
        strobe(1'b1, 1'b1, 5'd7, 32'h1234_5678, 1'b1);
        read_reg(5'd7, v);  check(v == 32'h1234_5678, "R5", "reg7", v, 32'h1234_5678);
        read_reg(5'd8, v);  check(v == 32'd0, "R5", "reg8 untouched", v, 32'd0);
        strobe(1'b1, 1'b1, 5'd7, 32'hCAFE_F00D, 1'b1);
        read_reg(5'd7, v);  check(v == 32'hCAFE_F00D, "R5", "reg7 overwrite", v, 32'hCAFE_F00D);
        strobe(1'b1, 1'b1, 5'd31, 32'hA5A5_0031, 1'b1);
        read_reg(5'd31, v); check(v == 32'hA5A5_0031, "R5", "reg31", v, 32'hA5A5_0031);
        read_reg(5'd0, v);  check(v == 32'd0, "R5", "reg0 untouched", v, 32'd0);

        // R4 / R6 non-writing strobes still count
        read_reg(5'd11, n);
        check(n == 32'd3, "R4", "ins after 3 writes", n, 32'd3);
        strobe(1'b0, 1'b1, 5'd9, 32'h0BAD_0009, 1'b0);
        strobe(1'b1, 1'b0, 5'd9, 32'h0BAD_1009, 1'b0);
        read_reg(5'd9, v);  check(v == 32'd0, "R6", "reg9 unwritten", v, 32'd0);
        read_reg(5'd11, v); check(v == n + 32'd2, "R4", "ins count", v, n + 32'd2);

        // R8 queue full back-pressure
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        host_out_ready = 1'b0;
        for (int i = 1; i <= 4; i++) strobe(1'b1, 1'b1, 5'(i), 32'h5000_0000 + i, 1'b1);
        read_reg(5'd11, n);
        check(done_ready == 1'b0, "R8", "ready low when full", {31'd0, done_ready}, 32'd0);
        @(negedge clk);
        done_valid = 1'b1; done_dst_valid = 1'b1; done_dst_kind = 1'b1;
        done_dst_idx = 5'd20; done_data = 32'h2020_2020;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_idx = 5'd11;
            #1;
            check(done_ready == 1'b0, "R8", "still stalled", {31'd0, done_ready}, 32'd0);
            check(rd_data == n, "R8", "stalled not counted", rd_data, n);
        end
        sb_q.push_back({5'd20, 32'h2020_2020});
        @(negedge clk);
        host_out_ready = 1'b1;
        #1;
        while (!done_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        done_valid = 1'b0; done_dst_valid = 1'b0;
        read_reg(5'd11, v);  check(v == n + 32'd1, "R8", "accepted after drain", v, n + 32'd1);
        read_reg(5'd20, v);  check(v == 32'h2020_2020, "R8", "reg20", v, 32'h2020_2020);

        // R7 all items delivered
        for (int i = 0; i < 40 && sb_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 32'd0);
        check(host_out_valid == 1'b0, "R7", "queue empty", {31'd0, host_out_valid}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule